// File: doc/BRIEF.md
# Cache Flush and Sync Sequencer

This block is the maintenance engine of a second-level cache. On a flush strobe it walks every line of the level-two tag/state array in ascending index order. Each valid line is back-invalidated in the inner first-level cache, any modified data is written to memory, and the line is left Invalid. On a sync strobe it walks the same way, but only Modified lines are touched. Each of those is inquired in the inner cache and written to memory, then kept as Exclusive with its data intact. When the inner cache answers an invalidate or inquire with modified data, that data goes to memory in place of the level-two copy and replaces it in the array.

Only one line is in progress at a time. A single-line snoop port lets an outside agent invalidate one line. A pending snoop is served between lines of a walk, ahead of the next walk line. Whenever the engine writes back to memory while a CPU cycle is in flight, it raises a backoff output. The CPU cycle is aborted and may only be retried after the writeback is acknowledged. A flush or sync strobe that arrives during a walk is held and served once the current walk completes, with flush taking precedence over sync.

The array read port has one cycle of latency. The outside agent must not issue a new snoop while an earlier one is still pending.

Top module: `cache_maint_seq`

## Requirements
- R1: After reset, walk_done, snp_done, boff, ic_req, mem_req, arr_rd_en and arr_wr_en are all low.
- R2: A walk visits line indices 0 to N_LINES-1 in ascending order. After the last line, walk_done is high for exactly one cycle.
- R3: A flush walk sends an invalidate (ic_op=0) to the inner cache exactly once for every line whose state is not Invalid. It sends nothing for Invalid lines. Every line ends Invalid (state code 2'b00; S=01, E=10, M=11).
- R4: A sync walk sends an inquire (ic_op=1) exactly once for every Modified line and for no other line. Those lines end Exclusive and hold the written-back data. Other lines keep their state and data.
- R5: Writeback data is the inner cache's data when it reports hit-modified, else the level-two copy if that line is Modified. A flushed Shared or Exclusive line with a clean inner cache causes no memory write.
- R6: mem_req stays high with stable mem_addr and mem_wdata until mem_ack. ic_req stays high until ic_done. ic_req and mem_req are never high together, and a new line starts only when the previous one is finished.
- R7: While mem_req is high, boff is high in every cycle after one in which cpu_cyc was high during the writeback. boff is never high without mem_req and falls together with mem_req after mem_ack.
- R8: A flush or sync strobe received during a walk is served as a separate walk after the current walk ends, giving a second walk_done pulse.
- R9: A snoop invalidates line snp_idx like a one-line flush. It is served before the next line of a running walk and ends with a one-cycle snp_done pulse.
- R10: If flush and sync are both pending when no walk runs, the flush walk runs first.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| flush_req | input | 1 | Flush strobe |
| sync_req | input | 1 | Sync strobe |
| snp_req | input | 1 | Snoop strobe |
| snp_idx | input | IDX_W | Line index of the snoop |
| walk_done | output | 1 | One-cycle pulse after a walk ends |
| snp_done | output | 1 | One-cycle pulse after a snoop ends |
| arr_rd_en | output | 1 | Tag/state/data array read enable |
| arr_rd_idx | output | IDX_W | Array read index |
| arr_rd_state | input | 2 | Line state, valid one cycle after the read |
| arr_rd_data | input | DATA_W | Line data, valid one cycle after the read |
| arr_wr_en | output | 1 | Array write enable |
| arr_wr_idx | output | IDX_W | Array write index |
| arr_wr_state | output | 2 | New line state |
| arr_wr_data | output | DATA_W | New line data |
| ic_req | output | 1 | Inner cache request, held until ic_done |
| ic_op | output | 1 | 0 = back-invalidate, 1 = inquire |
| ic_idx | output | IDX_W | Inner cache line index |
| ic_done | input | 1 | Inner cache response strobe |
| ic_hitm | input | 1 | Inner cache held the line modified |
| ic_wdata | input | DATA_W | Inner cache writeback data |
| mem_req | output | 1 | Memory write request, held until mem_ack |
| mem_addr | output | IDX_W | Memory write line index |
| mem_wdata | output | DATA_W | Memory write data |
| mem_ack | input | 1 | Memory write acknowledge |
| cpu_cyc | input | 1 | A CPU cycle is in flight |
| boff | output | 1 | Backoff: abort the CPU cycle |

## Verification
A wrong per-line decision shows at the ports within the handling of that one line. It appears as a missing or extra inner cache request, a request with the wrong ic_op, or a memory write with the wrong data. A bad final state shows up in the array write that ends the line. Scheduling faults show up later, when a walk or snoop completes. These include a skipped line, a lost held request, a snoop served after the walk reached its line, or flush and sync in the wrong order. They appear as a wrong count of walk_done pulses, or as inquire and invalidate counts per line that differ from the sequence the requirements give. A backoff fault shows up in the first cycle of a writeback that overlaps a CPU cycle.

// File: rtl/cfs_pkg.sv
package cfs_pkg;
  typedef enum logic [1:0] {
    ST_I = 2'b00,
    ST_S = 2'b01,
    ST_E = 2'b10,
    ST_M = 2'b11
  } line_st_t;

  typedef enum logic [1:0] {
    OP_FLUSH = 2'd0,
    OP_SYNC  = 2'd1,
    OP_SNOOP = 2'd2
  } walk_op_t;
endpackage

// File: rtl/cms_req_latch.sv
module cms_req_latch #(
  parameter int IDX_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [1:0]       walk_req,
  input  logic [1:0]       walk_take,
  output logic [1:0]       walk_pend,
  input  logic             snp_req,
  input  logic [IDX_W-1:0] snp_idx,
  input  logic             snp_take,
  output logic             snp_pend,
  output logic [IDX_W-1:0] snp_idx_q
);
  // bit 0: flush, bit 1: sync; a new strobe wins over a same-cycle take
  for (genvar g = 0; g < 2; g++) begin : g_walk
    always_ff @(posedge clk) begin
      if (rst)               walk_pend[g] <= 1'b0;
      else if (walk_req[g])  walk_pend[g] <= 1'b1;
      else if (walk_take[g]) walk_pend[g] <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      snp_pend  <= 1'b0;
      snp_idx_q <= '0;
    end else if (snp_req) begin
      snp_pend  <= 1'b1;
      snp_idx_q <= snp_idx;
    end else if (snp_take) begin
      snp_pend  <= 1'b0;
    end
  end
endmodule

// File: rtl/cms_sched.sv
module cms_sched
  import cfs_pkg::*;
#(
  parameter int N_LINES = 16,
  parameter int IDX_W   = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [1:0]       walk_pend,
  input  logic             snp_pend,
  input  logic [IDX_W-1:0] snp_idx,
  input  logic             ln_busy,
  input  logic             ln_fin,
  output logic             ln_start,
  output logic [IDX_W-1:0] ln_idx,
  output logic [1:0]       ln_op,
  output logic [1:0]       walk_take,
  output logic             snp_take,
  output logic             walk_done,
  output logic             snp_done
);
  localparam logic [IDX_W-1:0] LAST = IDX_W'(N_LINES - 1);

  logic             inflight;
  logic             walk_act;
  logic             walk_sync;
  logic             cur_snp;
  logic [IDX_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      inflight  <= 1'b0;
      walk_act  <= 1'b0;
      walk_sync <= 1'b0;
      cur_snp   <= 1'b0;
      cnt       <= '0;
      ln_start  <= 1'b0;
      ln_idx    <= '0;
      ln_op     <= OP_FLUSH;
      walk_take <= 2'b00;
      snp_take  <= 1'b0;
      walk_done <= 1'b0;
      snp_done  <= 1'b0;
    end else begin
      ln_start  <= 1'b0;
      walk_take <= 2'b00;
      snp_take  <= 1'b0;
      walk_done <= 1'b0;
      snp_done  <= 1'b0;
      if (ln_fin) begin
        inflight <= 1'b0;
        if (cur_snp) begin
          snp_done <= 1'b1;
        end else if (cnt == LAST) begin
          walk_act  <= 1'b0;
          walk_done <= 1'b1;
          cnt       <= '0;
        end else begin
          cnt <= cnt + 1'b1;
        end
      end else if (!inflight) begin
        if (snp_pend && !snp_take) begin
          ln_start <= 1'b1;
          ln_idx   <= snp_idx;
          ln_op    <= OP_SNOOP;
          cur_snp  <= 1'b1;
          inflight <= 1'b1;
          snp_take <= 1'b1;
        end else if (walk_act) begin
          ln_start <= 1'b1;
          ln_idx   <= cnt;
          ln_op    <= walk_sync ? OP_SYNC : OP_FLUSH;
          cur_snp  <= 1'b0;
          inflight <= 1'b1;
        end else if (walk_pend[0] && !walk_take[0]) begin
          walk_act     <= 1'b1;
          walk_sync    <= 1'b0;
          cnt          <= '0;
          walk_take[0] <= 1'b1;
        end else if (walk_pend[1] && !walk_take[1]) begin
          walk_act     <= 1'b1;
          walk_sync    <= 1'b1;
          cnt          <= '0;
          walk_take[1] <= 1'b1;
        end
      end
    end
  end

  // R6
  one_line_chk: assert property (@(posedge clk) disable iff (rst)
    ln_start |-> !ln_busy);
  // R2
  done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    walk_done |=> !walk_done);
  // R9
  snp_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    snp_done |=> !snp_done);
endmodule

// File: rtl/cms_line_eng.sv
module cms_line_eng
  import cfs_pkg::*;
#(
  parameter int IDX_W  = 4,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [IDX_W-1:0]  idx,
  input  logic [1:0]        op,
  output logic              busy,
  output logic              fin,
  output logic              arr_rd_en,
  output logic [IDX_W-1:0]  arr_rd_idx,
  input  logic [1:0]        arr_rd_state,
  input  logic [DATA_W-1:0] arr_rd_data,
  output logic              arr_wr_en,
  output logic [IDX_W-1:0]  arr_wr_idx,
  output logic [1:0]        arr_wr_state,
  output logic [DATA_W-1:0] arr_wr_data,
  output logic              ic_req,
  output logic              ic_op,
  output logic [IDX_W-1:0]  ic_idx,
  input  logic              ic_done,
  input  logic              ic_hitm,
  input  logic [DATA_W-1:0] ic_wdata,
  output logic              mem_req,
  output logic [IDX_W-1:0]  mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  input  logic              mem_ack,
  input  logic              cpu_cyc,
  output logic              boff
);
  typedef enum logic [2:0] {L_IDLE, L_RDW, L_EVAL, L_INNER, L_MEM} lst_t;

  lst_t              lst;
  walk_op_t          op_q;
  logic [IDX_W-1:0]  idx_q;
  logic [1:0]        st_q;
  logic [DATA_W-1:0] dat_q;
  logic [DATA_W-1:0] wb_q;
  logic              act;

  // a line needs work: any valid line for flush/snoop, only Modified for sync
  always_comb begin
    if (op_q == OP_SYNC) act = (arr_rd_state == ST_M);
    else                 act = (arr_rd_state != ST_I);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      lst          <= L_IDLE;
      op_q         <= OP_FLUSH;
      idx_q        <= '0;
      st_q         <= ST_I;
      dat_q        <= '0;
      wb_q         <= '0;
      fin          <= 1'b0;
      arr_rd_en    <= 1'b0;
      arr_wr_en    <= 1'b0;
      arr_wr_state <= ST_I;
      ic_req       <= 1'b0;
      ic_op        <= 1'b0;
      mem_req      <= 1'b0;
      boff         <= 1'b0;
    end else begin
      arr_rd_en <= 1'b0;
      arr_wr_en <= 1'b0;
      fin       <= 1'b0;
      case (lst)
        L_IDLE: if (start) begin
          idx_q     <= idx;
          op_q      <= walk_op_t'(op);
          arr_rd_en <= 1'b1;
          lst       <= L_RDW;
        end
        L_RDW: lst <= L_EVAL;
        L_EVAL: begin
          st_q  <= arr_rd_state;
          dat_q <= arr_rd_data;
          if (act) begin
            ic_req <= 1'b1;
            ic_op  <= (op_q == OP_SYNC);
            lst    <= L_INNER;
          end else begin
            fin <= 1'b1;
            lst <= L_IDLE;
          end
        end
        L_INNER: if (ic_done) begin
          ic_req       <= 1'b0;
          wb_q         <= ic_hitm ? ic_wdata : dat_q;
          arr_wr_state <= (op_q == OP_SYNC) ? ST_E : ST_I;
          if (ic_hitm || st_q == ST_M) begin
            mem_req <= 1'b1;
            boff    <= cpu_cyc;
            lst     <= L_MEM;
          end else begin
            arr_wr_en <= 1'b1;
            fin       <= 1'b1;
            lst       <= L_IDLE;
          end
        end
        L_MEM: begin
          if (mem_ack) begin
            mem_req   <= 1'b0;
            boff      <= 1'b0;
            arr_wr_en <= 1'b1;
            fin       <= 1'b1;
            lst       <= L_IDLE;
          end else begin
            boff <= boff | cpu_cyc;
          end
        end
        default: lst <= L_IDLE;
      endcase
    end
  end

  assign busy        = (lst != L_IDLE);
  assign arr_rd_idx  = idx_q;
  assign arr_wr_idx  = idx_q;
  assign ic_idx      = idx_q;
  assign mem_addr    = idx_q;
  assign arr_wr_data = wb_q;
  assign mem_wdata   = wb_q;

  // R6
  mem_hold_chk: assert property (@(posedge clk) disable iff (rst)
    mem_req && !mem_ack |=> mem_req && $stable(mem_addr) && $stable(mem_wdata));
  // R6
  ic_hold_chk: assert property (@(posedge clk) disable iff (rst)
    ic_req && !ic_done |=> ic_req);
  // R6
  one_xact_chk: assert property (@(posedge clk) disable iff (rst)
    !(ic_req && mem_req));
  // R7
  boff_cover_chk: assert property (@(posedge clk) disable iff (rst)
    mem_req && $past(mem_req) && $past(cpu_cyc) |-> boff);
  // R7
  boff_scope_chk: assert property (@(posedge clk) disable iff (rst)
    boff |-> mem_req);
  // R4
  no_mod_write_chk: assert property (@(posedge clk) disable iff (rst)
    arr_wr_en |-> arr_wr_state != ST_M);
endmodule

// File: rtl/cache_maint_seq.sv
module cache_maint_seq
  import cfs_pkg::*;
#(
  parameter int N_LINES = 16,
  parameter int DATA_W  = 32,
  parameter int IDX_W   = $clog2(N_LINES)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              flush_req,
  input  logic              sync_req,
  input  logic              snp_req,
  input  logic [IDX_W-1:0]  snp_idx,
  output logic              walk_done,
  output logic              snp_done,
  output logic              arr_rd_en,
  output logic [IDX_W-1:0]  arr_rd_idx,
  input  logic [1:0]        arr_rd_state,
  input  logic [DATA_W-1:0] arr_rd_data,
  output logic              arr_wr_en,
  output logic [IDX_W-1:0]  arr_wr_idx,
  output logic [1:0]        arr_wr_state,
  output logic [DATA_W-1:0] arr_wr_data,
  output logic              ic_req,
  output logic              ic_op,
  output logic [IDX_W-1:0]  ic_idx,
  input  logic              ic_done,
  input  logic              ic_hitm,
  input  logic [DATA_W-1:0] ic_wdata,
  output logic              mem_req,
  output logic [IDX_W-1:0]  mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  input  logic              mem_ack,
  input  logic              cpu_cyc,
  output logic              boff
);
  logic [1:0]       walk_pend;
  logic [1:0]       walk_take;
  logic             snp_pend;
  logic             snp_take;
  logic [IDX_W-1:0] snp_idx_q;
  logic             ln_start;
  logic [IDX_W-1:0] ln_idx;
  logic [1:0]       ln_op;
  logic             ln_busy;
  logic             ln_fin;

  cms_req_latch #(.IDX_W(IDX_W)) u_latch (
    .clk       (clk),
    .rst       (rst),
    .walk_req  ({sync_req, flush_req}),
    .walk_take (walk_take),
    .walk_pend (walk_pend),
    .snp_req   (snp_req),
    .snp_idx   (snp_idx),
    .snp_take  (snp_take),
    .snp_pend  (snp_pend),
    .snp_idx_q (snp_idx_q)
  );

  cms_sched #(.N_LINES(N_LINES), .IDX_W(IDX_W)) u_sched (
    .clk       (clk),
    .rst       (rst),
    .walk_pend (walk_pend),
    .snp_pend  (snp_pend),
    .snp_idx   (snp_idx_q),
    .ln_busy   (ln_busy),
    .ln_fin    (ln_fin),
    .ln_start  (ln_start),
    .ln_idx    (ln_idx),
    .ln_op     (ln_op),
    .walk_take (walk_take),
    .snp_take  (snp_take),
    .walk_done (walk_done),
    .snp_done  (snp_done)
  );

  cms_line_eng #(.IDX_W(IDX_W), .DATA_W(DATA_W)) u_eng (
    .clk          (clk),
    .rst          (rst),
    .start        (ln_start),
    .idx          (ln_idx),
    .op           (ln_op),
    .busy         (ln_busy),
    .fin          (ln_fin),
    .arr_rd_en    (arr_rd_en),
    .arr_rd_idx   (arr_rd_idx),
    .arr_rd_state (arr_rd_state),
    .arr_rd_data  (arr_rd_data),
    .arr_wr_en    (arr_wr_en),
    .arr_wr_idx   (arr_wr_idx),
    .arr_wr_state (arr_wr_state),
    .arr_wr_data  (arr_wr_data),
    .ic_req       (ic_req),
    .ic_op        (ic_op),
    .ic_idx       (ic_idx),
    .ic_done      (ic_done),
    .ic_hitm      (ic_hitm),
    .ic_wdata     (ic_wdata),
    .mem_req      (mem_req),
    .mem_addr     (mem_addr),
    .mem_wdata    (mem_wdata),
    .mem_ack      (mem_ack),
    .cpu_cyc      (cpu_cyc),
    .boff         (boff)
  );
endmodule

// File: tb/cache_maint_seq_bench.sv
`timescale 1ns/1ps
module cache_maint_seq_bench;
  localparam int N  = 16;
  localparam int DW = 32;
  localparam int IW = $clog2(N);

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic flush_req = 0, sync_req = 0, snp_req = 0;
  logic [IW-1:0] snp_idx = '0;
  logic walk_done, snp_done;
  logic arr_rd_en, arr_wr_en;
  logic [IW-1:0] arr_rd_idx, arr_wr_idx;
  logic [1:0] arr_rd_state = 2'b00;
  logic [DW-1:0] arr_rd_data = '0;
  logic [1:0] arr_wr_state;
  logic [DW-1:0] arr_wr_data;
  logic ic_req, ic_op;
  logic [IW-1:0] ic_idx;
  logic ic_done = 0, ic_hitm = 0;
  logic [DW-1:0] ic_wdata = '0;
  logic mem_req;
  logic [IW-1:0] mem_addr;
  logic [DW-1:0] mem_wdata;
  logic mem_ack = 0;
  logic cpu_cyc = 0;
  logic boff;

  always #5 clk = ~clk;

  cache_maint_seq #(.N_LINES(N), .DATA_W(DW)) u_cache_maint_seq (
    .clk(clk), .rst(rst), .flush_req(flush_req), .sync_req(sync_req),
    .snp_req(snp_req), .snp_idx(snp_idx), .walk_done(walk_done), .snp_done(snp_done),
    .arr_rd_en(arr_rd_en), .arr_rd_idx(arr_rd_idx), .arr_rd_state(arr_rd_state),
    .arr_rd_data(arr_rd_data), .arr_wr_en(arr_wr_en), .arr_wr_idx(arr_wr_idx),
    .arr_wr_state(arr_wr_state), .arr_wr_data(arr_wr_data), .ic_req(ic_req),
    .ic_op(ic_op), .ic_idx(ic_idx), .ic_done(ic_done), .ic_hitm(ic_hitm),
    .ic_wdata(ic_wdata), .mem_req(mem_req), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_ack(mem_ack), .cpu_cyc(cpu_cyc), .boff(boff)
  );

  // live models
  logic [1:0]    l2_st  [N];
  logic [DW-1:0] l2_dat [N];
  logic          ic_mod [N];
  logic [DW-1:0] ic_dat [N];
  logic [DW-1:0] mem    [N];
  int mem_cnt [N];
  int inv_cnt [N];
  int inq_cnt [N];
  int ic_log  [64];
  int ic_log_n;
  // expected models
  logic [1:0]    x_st  [N];
  logic [DW-1:0] x_dat [N];
  logic          x_icm [N];
  logic [DW-1:0] x_icd [N];
  logic [DW-1:0] x_mem [N];
  int x_cnt [N];
  int x_inv [N];
  int x_inq [N];

  int n_chk = 0, n_fail = 0;
  int done_cnt = 0, snpd_cnt = 0, boff_seen = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // array: registered read, write at the edge
  initial forever begin
    @(posedge clk);
    if (arr_rd_en) begin
      arr_rd_state <= l2_st[arr_rd_idx];
      arr_rd_data  <= l2_dat[arr_rd_idx];
    end
    if (arr_wr_en) begin
      l2_st[arr_wr_idx]  <= arr_wr_state;
      l2_dat[arr_wr_idx] <= arr_wr_data;
    end
  end

  // inner cache responder
  initial forever begin
    @(negedge clk);
    if (ic_req) begin
      repeat ($urandom_range(0, 3)) @(negedge clk);
      if (ic_op) inq_cnt[ic_idx]++; else inv_cnt[ic_idx]++;
      if (ic_log_n < 64) begin ic_log[ic_log_n] = int'(ic_idx); ic_log_n++; end
      ic_hitm  = ic_mod[ic_idx];
      ic_wdata = ic_dat[ic_idx];
      ic_mod[ic_idx] = 1'b0;
      ic_done  = 1'b1;
      @(negedge clk);
      ic_done  = 1'b0;
      ic_hitm  = 1'b0;
    end
  end

  // memory responder
  initial forever begin
    @(negedge clk);
    if (mem_req) begin
      repeat ($urandom_range(0, 4)) @(negedge clk);
      mem[mem_addr] = mem_wdata;
      mem_cnt[mem_addr]++;
      mem_ack = 1'b1;
      @(negedge clk);
      mem_ack = 1'b0;
    end
  end

  // port monitor and CPU cycle driver
  initial begin
    logic p_req, p_ack, p_cpu, p_wd, p_sd;
    logic [IW-1:0] p_addr;
    logic [DW-1:0] p_data;
    p_req = 0; p_ack = 0; p_cpu = 0; p_wd = 0; p_sd = 0; p_addr = '0; p_data = '0;
    forever begin
      @(negedge clk); #1;
      if (!rst) begin
        if (p_req && !p_ack && !(mem_req && mem_addr == p_addr && mem_wdata == p_data))
          chk(0, "R6", "mem request not held", {mem_req, mem_addr}, {1'b1, p_addr});
        if (ic_req && mem_req) chk(0, "R6", "ic_req with mem_req", 1, 0);
        if (mem_req && p_req && p_cpu && !boff) chk(0, "R7", "boff missing", boff, 1);
        if (boff && !mem_req) chk(0, "R7", "boff without mem_req", boff, 0);
        if (walk_done && p_wd) chk(0, "R2", "walk_done wider than one cycle", 2, 1);
        if (snp_done && p_sd) chk(0, "R9", "snp_done wider than one cycle", 2, 1);
        if (walk_done) done_cnt++;
        if (snp_done) snpd_cnt++;
        if (boff) boff_seen++;
      end
      p_req = mem_req; p_ack = mem_ack; p_addr = mem_addr; p_data = mem_wdata;
      p_wd = walk_done; p_sd = snp_done;
      cpu_cyc = boff ? 1'b0 : ($urandom_range(0, 1) == 1);
      p_cpu = cpu_cyc;
    end
  end

  task automatic preload();
    for (int i = 0; i < N; i++) begin
      l2_st[i]  = 2'($urandom_range(0, 3));
      l2_dat[i] = $urandom;
      ic_mod[i] = (l2_st[i] == 2'b11) && ($urandom_range(0, 1) == 1);
      ic_dat[i] = $urandom;
      mem[i] = '0; mem_cnt[i] = 0; inv_cnt[i] = 0; inq_cnt[i] = 0;
    end
    ic_log_n = 0;
  endtask

  task automatic snap();
    for (int i = 0; i < N; i++) begin
      x_st[i] = l2_st[i]; x_dat[i] = l2_dat[i]; x_icm[i] = ic_mod[i];
      x_icd[i] = ic_dat[i]; x_mem[i] = '0; x_cnt[i] = 0; x_inv[i] = 0; x_inq[i] = 0;
    end
  endtask

  task automatic m_flush_line(input int i);
    if (x_st[i] != 2'b00) begin
      x_inv[i]++;
      if (x_icm[i]) begin
        x_mem[i] = x_icd[i]; x_cnt[i]++; x_dat[i] = x_icd[i]; x_icm[i] = 1'b0;
      end else if (x_st[i] == 2'b11) begin
        x_mem[i] = x_dat[i]; x_cnt[i]++;
      end
      x_st[i] = 2'b00;
    end
  endtask

  task automatic m_sync_line(input int i);
    if (x_st[i] == 2'b11) begin
      x_inq[i]++;
      x_mem[i] = x_icm[i] ? x_icd[i] : x_dat[i];
      x_dat[i] = x_mem[i];
      x_icm[i] = 1'b0;
      x_cnt[i]++;
      x_st[i] = 2'b10;
    end
  endtask

  task automatic m_walk(input bit is_sync);
    for (int i = 0; i < N; i++) begin
      if (is_sync) m_sync_line(i); else m_flush_line(i);
    end
  endtask

  task automatic compare(input string req);
    for (int i = 0; i < N; i++) begin
      chk(l2_st[i] == x_st[i], req, $sformatf("line %0d state", i), l2_st[i], x_st[i]);
      if (x_st[i] != 2'b00)
        chk(l2_dat[i] == x_dat[i], req, $sformatf("line %0d data", i), l2_dat[i], x_dat[i]);
      chk(mem_cnt[i] == x_cnt[i], req, $sformatf("line %0d mem writes", i), mem_cnt[i], x_cnt[i]);
      if (x_cnt[i] > 0)
        chk(mem[i] == x_mem[i], req, $sformatf("line %0d mem data", i), mem[i], x_mem[i]);
      chk(inv_cnt[i] == x_inv[i], req, $sformatf("line %0d invalidates", i), inv_cnt[i], x_inv[i]);
      chk(inq_cnt[i] == x_inq[i], req, $sformatf("line %0d inquires", i), inq_cnt[i], x_inq[i]);
    end
  endtask

  task automatic strobe(input bit f, input bit s);
    @(negedge clk); flush_req = f; sync_req = s;
    @(negedge clk); flush_req = 0; sync_req = 0;
  endtask

  task automatic snoop(input int idx);
    @(negedge clk); snp_req = 1; snp_idx = IW'(idx);
    @(negedge clk); snp_req = 0;
  endtask

  task automatic wait_done(input int target);
    while (done_cnt < target) @(negedge clk);
    repeat (12) @(negedge clk);
  endtask

  task automatic wait_snp(input int target);
    while (snpd_cnt < target) @(negedge clk);
    repeat (12) @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    chk(0, "WATCHDOG", "run did not finish", 0, 1);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    int d0, ord_ok;
    void'($urandom(32'h5eed_1234));
    ic_log_n = 0;
    for (int i = 0; i < N; i++) begin
      l2_st[i] = 2'b00; l2_dat[i] = '0; ic_mod[i] = 0; ic_dat[i] = '0;
      mem[i] = '0; mem_cnt[i] = 0; inv_cnt[i] = 0; inq_cnt[i] = 0;
    end
    repeat (4) @(negedge clk);
    rst = 0;
    @(negedge clk); #2;
    // R1 reset state
    chk(walk_done == 0, "R1", "walk_done", walk_done, 0);
    chk(snp_done == 0,  "R1", "snp_done", snp_done, 0);
    chk(boff == 0,      "R1", "boff", boff, 0);
    chk(ic_req == 0,    "R1", "ic_req", ic_req, 0);
    chk(mem_req == 0,   "R1", "mem_req", mem_req, 0);
    chk(arr_rd_en == 0, "R1", "arr_rd_en", arr_rd_en, 0);
    chk(arr_wr_en == 0, "R1", "arr_wr_en", arr_wr_en, 0);

    // R2/R3/R5 directed flush: state pattern I,S,E,M repeating
    preload();
    for (int i = 0; i < N; i++) begin
      l2_st[i] = 2'(i % 4);
      ic_mod[i] = (i % 8 == 3);
    end
    snap(); m_walk(0);
    d0 = done_cnt;
    strobe(1, 0);
    wait_done(d0 + 1);
    chk(done_cnt == d0 + 1, "R2", "walk_done pulses after flush", done_cnt - d0, 1);
    compare("R3");
    ord_ok = 1;
    for (int k = 1; k < ic_log_n; k++) if (ic_log[k] <= ic_log[k-1]) ord_ok = 0;
    chk(ord_ok == 1, "R2", "ascending line order", ord_ok, 1);
    chk(ic_log_n == 3 * N / 4, "R3", "invalidate count", ic_log_n, 3 * N / 4);

    // R4/R5 directed sync
    preload();
    for (int i = 0; i < N; i++) begin
      l2_st[i] = 2'((i * 3) % 4);
      ic_mod[i] = (l2_st[i] == 2'b11) && (i % 2 == 0);
    end
    snap(); m_walk(1);
    d0 = done_cnt;
    strobe(0, 1);
    wait_done(d0 + 1);
    compare("R4");
    ord_ok = 1;
    for (int k = 1; k < ic_log_n; k++) if (ic_log[k] <= ic_log[k-1]) ord_ok = 0;
    chk(ord_ok == 1, "R2", "ascending sync order", ord_ok, 1);

    // R5 random walks
    for (int it = 0; it < 8; it++) begin
      bit s;
      s = (it % 2 == 1);
      preload(); snap(); m_walk(s);
      d0 = done_cnt;
      strobe(!s, s);
      wait_done(d0 + 1);
      compare("R5");
    end

    // R8 flush strobe during a sync walk
    preload(); snap(); m_walk(1); m_walk(0);
    d0 = done_cnt;
    strobe(0, 1);
    repeat (10) @(negedge clk);
    strobe(1, 0);
    wait_done(d0 + 2);
    chk(done_cnt == d0 + 2, "R8", "walk_done pulses", done_cnt - d0, 2);
    compare("R8");

    // R10 flush and sync together: flush runs first
    preload(); snap(); m_walk(0); m_walk(1);
    d0 = done_cnt;
    strobe(1, 1);
    wait_done(d0 + 2);
    chk(done_cnt == d0 + 2, "R10", "walk_done pulses", done_cnt - d0, 2);
    compare("R10");

    // R9 snoop during a sync walk, served before the walk reaches the line
    preload();
    l2_st[N-1] = 2'b11; ic_mod[N-1] = 1'b1;
    snap(); m_flush_line(N-1); m_walk(1);
    d0 = done_cnt;
    strobe(0, 1);
    repeat (5) @(negedge clk);
    snoop(N-1);
    wait_done(d0 + 1);
    chk(snpd_cnt == 1, "R9", "snp_done pulses", snpd_cnt, 1);
    compare("R9");

    // R9 snoop on an Invalid line while idle: no inner request, line stays Invalid
    preload();
    l2_st[3] = 2'b00;
    snap(); m_flush_line(3);
    snoop(3);
    wait_snp(2);
    chk(snpd_cnt == 2, "R9", "snp_done on idle snoop", snpd_cnt, 2);
    compare("R9");

    // R7 coverage of the backoff path
    chk(boff_seen > 0, "R7", "boff raised at least once", boff_seen, 1);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule